// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Guard

This block is a synchronous SPI master that runs entirely from one reference clock. A one-cycle start request loads a parallel transmit word and selects one of several chip-select lines. The block then drives the serial clock, shifts the word out on MOSI with the most significant bit first, and samples the slave's reply on MISO. When the word is complete it returns the received word together with a one-cycle done pulse. Clock polarity, clock phase, divider setting and guard length are captured from the inputs at start, so each transfer can use a different mode.

The serial clock comes from a divider selector. Code 0 is the bypass setting: the half-period is one reference cycle and there is no fractional guard step. Code k (k ≥ 1) gives an even ratio of 2^k, so the half-period is 2^(k-1) reference cycles. A 2-bit guard code G sets the time from chip-select assertion to the first clock edge (the lead) and from the last clock edge to chip-select release (the lag). Two guard rules exist. The full-step rule counts (2G+1) half-periods, which is (G + ½) clock periods. The short rule equals the full-step rule when divided, and is G+1 reference cycles in bypass. In phase 0 the lead uses the short rule and the lag uses the full-step rule. Phase 1 swaps the two.

Top module: `spi_guard_master`

## Requirements
- R1: While reset is held and right after it, every cs_n line is high, sclk is 0, busy is 0, done is 0 and rx_data is 0.
- R2: While idle, sclk takes the value of cpol one reference cycle after cpol is applied.
- R3: A start pulse is accepted only while busy is low. A start pulse seen while busy has no effect on the word sent, the word received, the chip-select line or the number of transfers.
- R4: busy and the selected chip select change on the same clock edge. While busy, cs_n bit cs_sel is 0 and every other bit is 1. While idle, all cs_n bits are 1.
- R5: Each transfer has exactly 2*WIDTH sclk edges, spaced H reference cycles apart. H is 1 for div_sel 0 and 2^(div_sel-1) otherwise.
- R6: The lead is measured in reference cycles from cs_n falling to the first sclk edge. With cpha=0 it is the short rule S: G+1 when div_sel is 0, (2G+1)*H otherwise. With cpha=1 it is the full-step rule F = (2G+1)*H, and in bypass F is 2G+1.
- R7: The lag is measured from the last sclk edge to cs_n rising. It is F with cpha=0 and S with cpha=1.
- R8: Data moves most significant bit first. MOSI changes only on launch edges and MISO is sampled on capture edges. The launch edge is the leading edge (the first edge of a bit, away from the idle level) when cpha=1, and the trailing edge when cpha=0. After the transfer, rx_data holds the WIDTH bits captured, the first in the top bit, for every combination of cpol and cpha.
- R9: With cpha=0, MOSI carries tx_data[WIDTH-1] from the cycle in which chip select asserts, before the first sclk edge.
- R10: done is high for exactly one cycle per transfer. It rises on the same edge on which cs_n returns high and busy falls, and rx_data is valid with it.
- R11: When done is high, sclk is back at the polarity that was captured at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer request |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Clock phase: 0 launches data on trailing edges, 1 on leading edges |
| tcs | input | 2 | Guard code G |
| div_sel | input | SELW | Divider selector, 0 selects bypass |
| cs_sel | input | max(1,clog2(NCS)) | Index of the chip-select line to assert |
| tx_data | input | WIDTH | Word to transmit |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | NCS | Active-low chip selects |
| busy | output | 1 | High from chip-select assertion to release |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | WIDTH | Last received word |

## Verification
A behavioural slave decodes the four cpol/cpha combinations from the edge sequence it observes and exchanges words with the master. This separates a wrong launch/capture assignment, which corrupts both received words, from a bit-order error. A directed sweep covers every guard code with divider codes 0 to 3 in all modes. It tells the bypass short rule apart from the full-step rule, and it also catches the lead/lag swap with phase, because each swap changes the measured interval by a known number of cycles. Seeded random transfers with wider divider codes and random data add coverage, and one transfer at the largest ratio exercises the widest counter. Directed cases cover idle polarity tracking, the second chip-select line, and a start pulse applied in the middle of a transfer.

// File: rtl/spi_guard_master.sv
module spi_guard_master #(
  parameter int WIDTH = 8,
  parameter int NCS   = 2,
  parameter int SELW  = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 cpol,
  input  logic                                 cpha,
  input  logic [1:0]                           tcs,
  input  logic [SELW-1:0]                      div_sel,
  input  logic [(NCS > 1 ? $clog2(NCS) : 1)-1:0] cs_sel,
  input  logic [WIDTH-1:0]                     tx_data,
  input  logic                                 miso,
  output logic                                 sclk,
  output logic                                 mosi,
  output logic [NCS-1:0]                       cs_n,
  output logic                                 busy,
  output logic                                 done,
  output logic [WIDTH-1:0]                     rx_data
);
  localparam int HMAX = 1 << ((1 << SELW) - 2);
  localparam int CNTW = $clog2(7 * HMAX + 1);
  localparam int ECW  = $clog2(2 * WIDTH + 1);

  typedef enum logic [1:0] {IDLE, RUN, LAG} st_t;

  st_t              st;
  logic [CNTW-1:0]  cnt, h_q, lag_q;
  logic [ECW-1:0]   edges;
  logic             sclk_q, pha_q, pol_q, done_q;
  logic [NCS-1:0]   cs_q;
  logic [WIDTH-1:0] sh, rx_sh, rx_q;

  logic [CNTW-1:0]  half, g_full, g_short;
  logic [ECW-1:0]   nxt;
  logic             capture, shift_ok;

  assign half    = (div_sel == '0) ? CNTW'(1) : (CNTW'(1) << (div_sel - SELW'(1)));
  assign g_full  = CNTW'({tcs, 1'b1}) * half;
  assign g_short = (div_sel == '0) ? CNTW'(tcs) + CNTW'(1) : g_full;

  assign nxt      = edges + ECW'(1);
  assign capture  = nxt[0] ^ pha_q;
  assign shift_ok = !capture && (nxt != ECW'(1)) && (nxt != ECW'(2 * WIDTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      h_q    <= '0;
      lag_q  <= '0;
      edges  <= '0;
      sclk_q <= 1'b0;
      pha_q  <= 1'b0;
      pol_q  <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= '1;
      sh     <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            st    <= RUN;
            cs_q  <= ~(NCS'(1) << cs_sel);
            sh    <= tx_data;
            pha_q <= cpha;
            pol_q <= cpol;
            h_q   <= half;
            lag_q <= cpha ? g_short : g_full;
            cnt   <= (cpha ? g_full : g_short) - CNTW'(1);
            edges <= '0;
          end
        end
        RUN: begin
          if (cnt == '0) begin
            sclk_q <= ~sclk_q;
            edges  <= nxt;
            if (capture) rx_sh <= {rx_sh[WIDTH-2:0], miso};
            if (shift_ok) sh <= sh << 1;
            if (nxt == ECW'(2 * WIDTH)) begin
              st  <= LAG;
              cnt <= lag_q - CNTW'(1);
            end else begin
              cnt <= h_q - CNTW'(1);
            end
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            st     <= IDLE;
            cs_q   <= '1;
            done_q <= 1'b1;
            rx_q   <= rx_sh;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh[WIDTH-1];
  assign cs_n    = cs_q;
  assign busy    = (st != IDLE);
  assign done    = done_q;
  assign rx_data = rx_q;

  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(rst_n)) |-> (sclk == $past(cpol)));

  a_r4_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~cs_n) == 1));

  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == '1));

  a_r4_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && (cs_n == '1) && $past(cs_n != '1)));

  a_r11_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == pol_q));
endmodule

// File: tb/spi_guard_master_tb_top.sv
module spi_guard_master_tb_top;
  localparam int W    = 8;
  localparam int NCS  = 2;
  localparam int SELW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [1:0] tcs = '0;
  logic [SELW-1:0] div_sel = '0;
  logic [0:0] cs_sel = '0;
  logic [W-1:0] tx_data = '0;
  logic miso = 1'b0;
  logic sclk, mosi, busy, done;
  logic [NCS-1:0] cs_n;
  logic [W-1:0] rx_data;

  always #5 clk = ~clk;

  spi_guard_master #(.WIDTH(W), .NCS(NCS), .SELW(SELW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
    .tcs(tcs), .div_sel(div_sel), .cs_sel(cs_sel), .tx_data(tx_data),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
    .done(done), .rx_data(rx_data));

  int checks = 0, errors = 0;
  int cyc = 0, fall_c = 0, first_c = 0, last_c = 0, rise_c = 0;
  int nedge = 0, bad_half = 0, done_cnt = 0, cs_bad = 0, exp_h = 1;
  bit m_pha = 1'b0;
  logic [NCS-1:0] exp_mask = '1, p_csn = '1;
  logic p_sclk = 1'b0;
  logic [W-1:0] s_tx = '0, s_rx = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hcyc(input int sel);
    return (sel == 0) ? 1 : (1 << (sel - 1));
  endfunction
  function automatic int g_full(input int t, input int sel);
    return (2 * t + 1) * hcyc(sel);
  endfunction
  function automatic int g_short(input int t, input int sel);
    return (sel == 0) ? t + 1 : g_full(t, sel);
  endfunction

  always @(negedge clk) begin
    int n, idx;
    bit cap;
    cyc++;
    if (p_csn == '1 && cs_n != '1) begin
      fall_c = cyc; nedge = 0; bad_half = 0; s_rx = '0;
      if (!m_pha) miso = s_tx[W-1];
    end
    if (cs_n != '1 && cs_n != exp_mask) cs_bad++;
    if (p_csn != '1 && cs_n != '1 && sclk != p_sclk) begin
      nedge++;
      n = nedge;
      if (n == 1) first_c = cyc;
      else if (cyc - last_c != exp_h) bad_half++;
      last_c = cyc;
      cap = ((n % 2) == 1) == (m_pha == 1'b0);
      if (cap) begin
        idx = m_pha ? (n / 2 - 1) : ((n - 1) / 2);
        if (idx < W) s_rx[W-1-idx] = mosi;
      end else begin
        idx = m_pha ? ((n - 1) / 2) : (n / 2);
        if (idx < W) miso = s_tx[W-1-idx];
      end
    end
    if (p_csn != '1 && cs_n == '1) rise_c = cyc;
    if (done) done_cnt++;
    p_sclk = sclk;
    p_csn  = cs_n;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic xfer(input bit pol, input bit pha, input int t, input int sel,
                      input int cs, input logic [W-1:0] tx, input logic [W-1:0] stx,
                      input bit poke);
    int d0, tmo;
    d0 = done_cnt; cs_bad = 0;
    s_tx = stx; m_pha = pha; exp_h = hcyc(sel);
    exp_mask = ~(NCS'(1) << cs);
    cpol = pol; cpha = pha; tcs = 2'(t); div_sel = SELW'(sel);
    cs_sel = 1'(cs); tx_data = tx; start = 1'b1;
    step();
    start = 1'b0;
    chk(busy == 1'b1, "R4 busy with cs assertion", busy, 1);
    chk(cs_n == exp_mask, "R4 selected cs low", cs_n, exp_mask);
    if (!pha) chk(mosi == tx[W-1], "R9 first bit before first edge", mosi, tx[W-1]);
    tmo = 0;
    while (!done && tmo < 6000) begin
      if (poke && tmo == 3) begin
        start = 1'b1; tx_data = ~tx; cs_sel = 1'(cs ^ 1); cpha = ~pha;
      end else if (poke && tmo == 4) begin
        start = 1'b0;
      end
      step();
      tmo++;
    end
    chk(done == 1'b1, "R10 done reached", done, 1);
    chk(busy == 1'b0 && cs_n == '1, "R10 release with done", {busy, cs_n}, 0 + {1'b0, {NCS{1'b1}}});
    chk(rx_data == stx, "R8 master received word", rx_data, stx);
    chk(s_rx == tx, "R8 slave received word", s_rx, tx);
    chk(sclk == pol, "R11 sclk at rest level", sclk, pol);
    chk(nedge == 2 * W, "R5 edge count", nedge, 2 * W);
    chk(bad_half == 0, "R5 half-period spacing", bad_half, 0);
    chk(first_c - fall_c == (pha ? g_full(t, sel) : g_short(t, sel)),
        "R6 lead", first_c - fall_c, pha ? g_full(t, sel) : g_short(t, sel));
    chk(rise_c - last_c == (pha ? g_short(t, sel) : g_full(t, sel)),
        "R7 lag", rise_c - last_c, pha ? g_short(t, sel) : g_full(t, sel));
    chk(cs_bad == 0, poke ? "R3 cs unchanged by late start" : "R4 only selected cs low", cs_bad, 0);
    step();
    chk(done == 1'b0 && done_cnt - d0 == 1, "R10 single done pulse", done_cnt - d0, 1);
    if (poke) begin
      step(); step();
      chk(busy == 1'b0 && cs_n == '1, "R3 no restart from late start", busy, 0);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4721));
    repeat (5) @(negedge clk);
    #1;
    chk(cs_n == '1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && rx_data == '0,
        "R1 reset state", {cs_n, sclk, busy, done}, {{NCS{1'b1}}, 3'b000});
    rst_n = 1'b1;
    step();
    chk(cs_n == '1 && sclk == 1'b0 && busy == 1'b0 && rx_data == '0,
        "R1 state after reset", {cs_n, sclk, busy}, {{NCS{1'b1}}, 2'b00});

    cpol = 1'b1;
    step();
    chk(sclk == 1'b1, "R2 idle follows cpol high", sclk, 1);
    cpol = 1'b0;
    step();
    chk(sclk == 1'b0, "R2 idle follows cpol low", sclk, 0);

    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 4; t++)
        for (int s = 0; s < 4; s++)
          xfer(m[1], m[0], t, s, (t + s) % NCS, W'(8'hA5 ^ (t * 16 + s)),
               W'(8'h3C + m * 37 + t), 1'b0);

    xfer(1'b0, 1'b0, 0, 0, 1, 8'h80, 8'h01, 1'b0);
    xfer(1'b1, 1'b1, 3, 0, 0, 8'hFF, 8'h00, 1'b0);
    xfer(1'b0, 1'b1, 2, 7, 1, 8'h5A, 8'hC3, 1'b0);
    xfer(1'b1, 1'b0, 1, 2, 0, 8'h96, 8'h69, 1'b1);
    xfer(1'b0, 1'b1, 0, 1, 1, 8'h0F, 8'hF0, 1'b1);

    for (int i = 0; i < 40; i++) begin
      int s;
      s = int'($urandom_range(5, 0));
      xfer(1'($urandom), 1'($urandom), int'($urandom_range(3, 0)), s,
           int'($urandom_range(NCS - 1, 0)), W'($urandom), W'($urandom), 1'b0);
    end

    cpol = 1'b1;
    step();
    chk(sclk == 1'b1, "R2 idle follows cpol after transfers", sclk, 1);
    finish_up();
  end
endmodule